// File: doc/BRIEF.md
# Store Queue Commit and Writeback

This block holds the stores of an out-of-order core in a circular buffer from allocation until the data cache has taken them. Stores enter at the tail in program order. They stay speculative until a commit point names the youngest sequence number that is safe, or until they are flagged non-speculative at entry. Eligible stores are then driven one at a time, oldest first, onto a write channel toward the data cache. A write that hits completes at once. A write that misses completes later through a separate completion input that names the entry.

Entries leave the queue only from the head and only in order. Completions may arrive out of order, and the head then moves past the whole run of completed entries in a single step. A squash removes the uncommitted younger stores from the tail. Zero-size stores and prefetches are retired without a cache write. The block can also hold one stalled load against a named store. When that store completes, it issues a one-cycle replay pulse that carries the load's index.

Top module: `sq_commit_wb`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `alloc_ready` is 1, `wr_valid` is 0 and `replay_valid` is 0.
- R2: Stores are placed at consecutive indices that wrap modulo DEPTH, and `alloc_idx` shows the index the next store will take. At most DEPTH-1 stores are held. With DEPTH-1 stores held, `alloc_ready` is 0 and a request on `alloc_valid` has no effect.
- R3: A store is not written before it is eligible. A commit makes every held store with sequence number at most `commit_seq` eligible.
- R4: Eligible stores are written strictly in allocation order, at most one per cycle. Each request carries that store's address, data, size and index. A request is held unchanged until `wr_ready` is 1.
- R5: While `cache_blocked` is 1, no write request is raised.
- R6: A write accepted with `wr_hit` at 1 completes at once. A write accepted with `wr_hit` at 0 completes only when `cpl_valid` is 1 with `cpl_idx` equal to its index.
- R7: Stores retire from the head in order. A completed store stays held while any older store is incomplete. Once the oldest store completes, the whole run of completed stores behind it retires together on the clock edge after that completion is recorded.
- R8: An eligible store of size 0 completes without a write request, even while `cache_blocked` is 1.
- R9: An eligible prefetch entry completes without a write request when the cache is not blocked.
- R10: A store allocated with `alloc_nonspec` at 1 is eligible without any commit.
- R11: A squash removes every held store whose sequence number is greater than `squash_seq`. The tail returns, so the next store reuses the first freed index.
- R12: When a completion is recorded for the store whose sequence number was given with `stall_set`, `replay_valid` is 1 for exactly one cycle and `replay_ld_idx` carries the stalled load's index. A completion of any other store gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store size in bytes (0 means no access) |
| alloc_pref | input | 1 | Entry is a prefetch |
| alloc_nonspec | input | 1 | Entry is eligible at once |
| alloc_ready | output | 1 | Queue has a free entry |
| alloc_idx | output | IW | Index the next store takes |
| commit_valid | input | 1 | Commit point this cycle |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash this cycle |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Cache accepts the write |
| wr_hit | input | 1 | Accepted write hit in the cache |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_size | output | SIZE_W | Write size |
| wr_idx | output | IW | Queue index of the write |
| cache_blocked | input | 1 | Cache cannot take writes |
| cpl_valid | input | 1 | Late completion of a missed write |
| cpl_idx | input | IW | Index of the completing entry |
| stall_set | input | 1 | Register a stalled load |
| stall_seq | input | SEQ_W | Store the load waits on |
| stall_ld_idx | input | LQ_IW | Index of the stalled load |
| replay_valid | output | 1 | One-cycle replay pulse |
| replay_ld_idx | output | LQ_IW | Load to replay |
| occupancy | output | CW | Number of held stores |

## Verification
The properties assume that sequence numbers rise strictly in allocation order and do not wrap while held. They also assume that a squash never reaches an eligible store, that allocation and squash never fall in the same cycle, that `cpl_idx` only names a written miss still awaiting completion, and that `stall_set` is raised only while no stall is pending. The directed stimulus takes every sequence number from one rising counter. It squashes only uncommitted stores, keeps allocation, commit and squash in separate cycles, and sends completions only for indices it has seen written with `wr_hit` at 0. It names only a store that is still outstanding when it raises a stall.

// File: rtl/sq_pkg.sv
// Package: shared types for the store queue.
// Assumes nothing beyond SystemVerilog 2017.
package sq_pkg;
    // Action taken by the writeback step on the entry at the writeback pointer
    typedef enum logic [1:0] {
        WB_IDLE   = 2'd0,
        WB_BYPASS = 2'd1,
        WB_SEND   = 2'd2
    } wb_act_e;
endpackage

// File: rtl/sq_retire_scan.sv
// Module: counts the run of completed entries starting at the head.
// Assumes cnt never exceeds DEPTH-1 and done[] is valid for held entries.
module sq_retire_scan #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [IW-1:0]    head,
    input  logic [CW-1:0]    cnt,
    input  logic [DEPTH-1:0] done,
    output logic [CW-1:0]    ret_n
);
    // Walk from the head while entries are held and completed
    always_comb begin
        int  n;
        int  idx;
        logic run;
        n   = 0;
        run = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            idx = int'(head) + k;
            if (idx >= DEPTH) idx -= DEPTH;
            if (run && (k < int'(cnt)) && done[idx]) n++;
            else run = 1'b0;
        end
        ret_n = CW'(n);
    end
endmodule

// File: rtl/sq_wb_step.sv
// Module: decides the writeback action for the entry at the writeback pointer.
// Assumes one entry is considered per cycle (a single write channel).
module sq_wb_step
    import sq_pkg::*;
(
    input  logic    have_elig,
    input  logic    at_tail,
    input  logic    ent_elig,
    input  logic    ent_zero,
    input  logic    ent_pref,
    input  logic    blocked,
    input  logic    wr_ready,
    input  logic    wr_hit,
    output wb_act_e act,
    output logic    wr_valid,
    output logic    advance,
    output logic    complete
);
    logic go;
    assign go = have_elig && !at_tail && ent_elig;

    // Choose bypass, send or idle for this cycle
    always_comb begin
        act = WB_IDLE;
        if (go && ent_zero)                  act = WB_BYPASS;
        else if (go && !blocked && ent_pref) act = WB_BYPASS;
        else if (go && !blocked)             act = WB_SEND;
    end

    // Derive handshake and completion from the chosen action
    always_comb begin
        wr_valid = (act == WB_SEND);
        advance  = (act == WB_BYPASS) || (wr_valid && wr_ready);
        complete = (act == WB_BYPASS) || (wr_valid && wr_ready && wr_hit);
    end
endmodule

// File: rtl/sq_stall_track.sv
// Module: holds one stalled load and pulses a replay when its store completes.
// Assumes stall_set is raised only while no stall is pending.
module sq_stall_track #(
    parameter int SEQ_W = 8,
    parameter int LQ_IW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_set,
    input  logic [SEQ_W-1:0] stall_seq,
    input  logic [LQ_IW-1:0] stall_ld_idx,
    input  logic             cmp_a_v,
    input  logic [SEQ_W-1:0] cmp_a_seq,
    input  logic             cmp_b_v,
    input  logic [SEQ_W-1:0] cmp_b_seq,
    output logic             replay_valid,
    output logic [LQ_IW-1:0] replay_ld_idx
);
    logic             active;
    logic [SEQ_W-1:0] wait_seq;
    logic [LQ_IW-1:0] wait_ld;
    logic             match;

    assign match = active && ((cmp_a_v && cmp_a_seq == wait_seq) ||
                              (cmp_b_v && cmp_b_seq == wait_seq));

    // Track the stall and emit a one-cycle replay on a matching completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active        <= 1'b0;
            wait_seq      <= '0;
            wait_ld       <= '0;
            replay_valid  <= 1'b0;
            replay_ld_idx <= '0;
        end else begin
            replay_valid <= 1'b0;
            if (match) begin
                active        <= 1'b0;
                replay_valid  <= 1'b1;
                replay_ld_idx <= wait_ld;
            end else if (stall_set) begin
                active   <= 1'b1;
                wait_seq <= stall_seq;
                wait_ld  <= stall_ld_idx;
            end
        end
    end
endmodule

// File: rtl/sq_commit_wb.sv
// Module: circular store queue with commit, in-order writeback and in-order retire.
// Assumes rising sequence numbers, no squash of eligible stores, and no
// allocation in a squash cycle.
module sq_commit_wb
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 4,
    parameter int LQ_IW  = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic              alloc_pref,
    input  logic              alloc_nonspec,
    output logic              alloc_ready,
    output logic [IW-1:0]     alloc_idx,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic              wr_hit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [SIZE_W-1:0] wr_size,
    output logic [IW-1:0]     wr_idx,
    input  logic              cache_blocked,
    input  logic              cpl_valid,
    input  logic [IW-1:0]     cpl_idx,
    input  logic              stall_set,
    input  logic [SEQ_W-1:0]  stall_seq,
    input  logic [LQ_IW-1:0]  stall_ld_idx,
    output logic              replay_valid,
    output logic [LQ_IW-1:0]  replay_ld_idx,
    output logic [CW-1:0]     occupancy
);
    // Entry storage
    logic [SEQ_W-1:0]  e_seq  [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [SIZE_W-1:0] e_size [DEPTH];
    logic [DEPTH-1:0]  e_pref;
    logic [DEPTH-1:0]  e_elig;
    logic [DEPTH-1:0]  e_done;

    // Pointers and counters
    logic [IW-1:0] head, tail, wbp;
    logic [CW-1:0] cnt, elig_cnt, ret_n;

    logic [DEPTH-1:0] in_q, mark, kill;
    logic             alloc_fire;
    logic             c_step;
    logic             advance;
    wb_act_e          act;

    function automatic logic [IW-1:0] ring_add(input logic [IW-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH) s -= DEPTH;
        return IW'(s);
    endfunction

    function automatic int ring_off(input int i, input logic [IW-1:0] h);
        int o;
        o = i - int'(h);
        if (o < 0) o += DEPTH;
        return o;
    endfunction

    assign alloc_ready = int'(cnt) < DEPTH - 1;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = tail;
    assign occupancy   = cnt;

    // Per-entry membership, commit marking and squash selection
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign in_q[g] = ring_off(g, head) < int'(cnt);
        assign mark[g] = commit_valid && in_q[g] && !e_elig[g] && (e_seq[g] <= commit_seq);
        assign kill[g] = squash_valid && in_q[g] && (e_seq[g] > squash_seq);
    end

    sq_retire_scan #(.DEPTH(DEPTH)) u_scan (
        .head  (head),
        .cnt   (cnt),
        .done  (e_done),
        .ret_n (ret_n)
    );

    sq_wb_step u_step (
        .have_elig (elig_cnt != '0),
        .at_tail   (wbp == tail),
        .ent_elig  (e_elig[wbp]),
        .ent_zero  (e_size[wbp] == '0),
        .ent_pref  (e_pref[wbp]),
        .blocked   (cache_blocked),
        .wr_ready  (wr_ready),
        .wr_hit    (wr_hit),
        .act       (act),
        .wr_valid  (wr_valid),
        .advance   (advance),
        .complete  (c_step)
    );

    assign wr_addr = e_addr[wbp];
    assign wr_data = e_data[wbp];
    assign wr_size = e_size[wbp];
    assign wr_idx  = wbp;

    sq_stall_track #(.SEQ_W(SEQ_W), .LQ_IW(LQ_IW)) u_stall (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_set     (stall_set),
        .stall_seq     (stall_seq),
        .stall_ld_idx  (stall_ld_idx),
        .cmp_a_v       (c_step),
        .cmp_a_seq     (e_seq[wbp]),
        .cmp_b_v       (cpl_valid),
        .cmp_b_seq     (e_seq[cpl_idx]),
        .replay_valid  (replay_valid),
        .replay_ld_idx (replay_ld_idx)
    );

    // Entry fields: load on allocation
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (alloc_fire && tail == IW'(g)) begin
                e_seq[g]  <= alloc_seq;
                e_addr[g] <= alloc_addr;
                e_data[g] <= alloc_data;
                e_size[g] <= alloc_size;
                e_pref[g] <= alloc_pref;
            end
        end

        // Entry flags: eligibility and completion
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_elig[g] <= 1'b0;
                e_done[g] <= 1'b0;
            end else if (alloc_fire && tail == IW'(g)) begin
                e_elig[g] <= alloc_nonspec;
                e_done[g] <= 1'b0;
            end else begin
                if (mark[g]) e_elig[g] <= 1'b1;
                if (kill[g]) e_elig[g] <= 1'b0;
                if ((c_step && wbp == IW'(g)) || (cpl_valid && cpl_idx == IW'(g)))
                    e_done[g] <= 1'b1;
            end
        end
    end

    // Pointers, occupancy and the eligible counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head     <= '0;
            tail     <= '0;
            wbp      <= '0;
            cnt      <= '0;
            elig_cnt <= '0;
        end else begin
            head <= ring_add(head, int'(ret_n));
            if (squash_valid)
                tail <= ring_add(head, int'(cnt) - $countones(kill));
            else if (alloc_fire)
                tail <= ring_add(tail, 1);
            if (advance) wbp <= ring_add(wbp, 1);
            cnt <= CW'(int'(cnt) + int'(alloc_fire) - int'(ret_n) - $countones(kill));
            elig_cnt <= CW'(int'(elig_cnt) + $countones(mark)
                            + int'(alloc_fire && alloc_nonspec)
                            - int'(c_step) - int'(cpl_valid));
        end
    end
endmodule

// File: rtl/sq_commit_wb_chk.sv
// Module: property checker bound to the store queue top.
// Assumes the input rules listed in the brief.
module sq_commit_wb_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int LQ_IW = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [IW-1:0]    wr_idx,
    input logic             cache_blocked,
    input logic             replay_valid,
    input logic [CW-1:0]    occupancy
);
    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH - 1);

    // R2
    full_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occupancy) == DEPTH - 1 && alloc_valid) |=> int'(occupancy) <= DEPTH - 1);

    // R5
    blocked_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_blocked |-> !wr_valid);

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (cache_blocked || (wr_valid && $stable(wr_idx))));

    // R12
    replay_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |=> !replay_valid);

    // R2
    ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ready == (int'(occupancy) < DEPTH - 1));
endmodule

bind sq_commit_wb sq_commit_wb_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LQ_IW(LQ_IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_idx        (wr_idx),
    .cache_blocked (cache_blocked),
    .replay_valid  (replay_valid),
    .occupancy     (occupancy)
);

// File: tb/tb_sq_commit_wb.sv
// Bench: directed scenarios for the store queue, one task per scenario.
module tb_sq_commit_wb;
    localparam int DEPTH = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, alloc_pref = 0, alloc_nonspec = 0;
    logic [7:0]  alloc_seq = 0;
    logic [15:0] alloc_addr = 0;
    logic [31:0] alloc_data = 0;
    logic [3:0]  alloc_size = 0;
    logic        alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic        commit_valid = 0, squash_valid = 0;
    logic [7:0]  commit_seq = 0, squash_seq = 0;
    logic        wr_valid, wr_ready = 1, wr_hit = 1, cache_blocked = 0;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_size;
    logic [IW-1:0] wr_idx;
    logic        cpl_valid = 0;
    logic [IW-1:0] cpl_idx = 0;
    logic        stall_set = 0;
    logic [7:0]  stall_seq = 0;
    logic [3:0]  stall_ld_idx = 0;
    logic        replay_valid;
    logic [3:0]  replay_ld_idx;
    logic [CW-1:0] occupancy;

    int tests = 0, fails = 0;
    int nseq = 1;
    int wn = 0;
    int wlog_idx [256];
    int wlog_addr[256];

    sq_commit_wb dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_size(alloc_size), .alloc_pref(alloc_pref),
        .alloc_nonspec(alloc_nonspec), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_hit(wr_hit),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .wr_idx(wr_idx),
        .cache_blocked(cache_blocked), .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
        .stall_set(stall_set), .stall_seq(stall_seq), .stall_ld_idx(stall_ld_idx),
        .replay_valid(replay_valid), .replay_ld_idx(replay_ld_idx),
        .occupancy(occupancy)
    );

    always #10 clk = ~clk;

    // Record accepted writes half a cycle before the accepting edge
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready && wn < 256) begin
            wlog_idx[wn]  = int'(wr_idx);
            wlog_addr[wn] = int'(wr_addr);
            wn++;
        end
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push(input logic [3:0] sz, input logic pf, input logic ns,
                        output int idx, output int sq);
        sq = nseq++;
        idx = int'(alloc_idx);
        alloc_valid = 1; alloc_seq = 8'(sq);
        alloc_addr = 16'(16'h100 + sq); alloc_data = 32'hA000_0000 + sq;
        alloc_size = sz; alloc_pref = pf; alloc_nonspec = ns;
        tick();
        alloc_valid = 0; alloc_pref = 0; alloc_nonspec = 0;
    endtask

    task automatic commit(input int sq);
        commit_valid = 1; commit_seq = 8'(sq);
        tick();
        commit_valid = 0;
    endtask

    task automatic t_reset;
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 wr_valid", int'(wr_valid), 0);
        chk("R1 replay_valid", int'(replay_valid), 0);
    endtask

    task automatic t_commit_order;
        int i0, i1, i2, s0, s1, s2;
        wn = 0;
        push(4, 0, 0, i0, s0); push(4, 0, 0, i1, s1); push(4, 0, 0, i2, s2);
        chk("R2 idx0", i0, 0); chk("R2 idx2", i2, 2);
        idle(4);
        chk("R3 no write before commit", wn, 0);
        chk("R2 occupancy 3", int'(occupancy), 3);
        commit(s1);
        idle(6);
        chk("R3 commit writes two", wn, 2);
        chk("R4 first idx", wlog_idx[0], 0);
        chk("R4 second idx", wlog_idx[1], 1);
        chk("R4 first addr", wlog_addr[0], 16'h100 + s0);
        chk("R7 occupancy after hits", int'(occupancy), 1);
        commit(s2);
        idle(6);
        chk("R4 third write", wn, 3);
        chk("R7 drained", int'(occupancy), 0);
    endtask

    task automatic t_blocked_hold;
        int ix, sx;
        wn = 0;
        cache_blocked = 1;
        push(4, 0, 0, ix, sx);
        commit(sx);
        idle(5);
        chk("R5 blocked no write", wn, 0);
        chk("R5 blocked wr_valid", int'(wr_valid), 0);
        wr_ready = 0; cache_blocked = 0;
        idle(3);
        chk("R4 held valid", int'(wr_valid), 1);
        chk("R4 held idx", int'(wr_idx), ix);
        chk("R4 held size", int'(wr_size), 4);
        chk("R4 held data", int'(wr_data == 32'hA000_0000 + sx), 1);
        wr_ready = 1;
        idle(4);
        chk("R4 accepted after ready", wn, 1);
        chk("R6 hit retired", int'(occupancy), 0);
    endtask

    task automatic t_miss_ooo;
        int ia, ib, sa, sb;
        wn = 0;
        wr_hit = 0;
        push(4, 0, 0, ia, sa); push(4, 0, 0, ib, sb);
        commit(sb);
        idle(5);
        wr_hit = 1;
        chk("R6 both written", wn, 2);
        chk("R6 misses held", int'(occupancy), 2);
        cpl_valid = 1; cpl_idx = IW'(ib);
        tick();
        cpl_valid = 0;
        tick();
        chk("R7 younger done, older pending", int'(occupancy), 2);
        cpl_valid = 1; cpl_idx = IW'(ia);
        tick();
        cpl_valid = 0;
        chk("R7 not yet retired", int'(occupancy), 2);
        tick();
        chk("R7 run retired together", int'(occupancy), 0);
    endtask

    task automatic t_zero_pref_nonspec;
        int ix, sx;
        wn = 0;
        cache_blocked = 1;
        push(0, 0, 0, ix, sx);
        commit(sx);
        idle(4);
        chk("R8 zero-size retired while blocked", int'(occupancy), 0);
        chk("R8 zero-size no write", wn, 0);
        cache_blocked = 0;
        push(4, 1, 0, ix, sx);
        commit(sx);
        idle(4);
        chk("R9 prefetch retired", int'(occupancy), 0);
        chk("R9 prefetch no write", wn, 0);
        push(4, 0, 1, ix, sx);
        idle(4);
        chk("R10 nonspec written", wn, 1);
        chk("R10 nonspec addr", wlog_addr[0], 16'h100 + sx);
        chk("R10 nonspec retired", int'(occupancy), 0);
    endtask

    task automatic t_squash;
        int ia, ib, ic, id, sa, sb, sc, sd;
        wn = 0;
        push(4, 0, 0, ia, sa); push(4, 0, 0, ib, sb); push(4, 0, 0, ic, sc);
        squash_valid = 1; squash_seq = 8'(sa);
        tick();
        squash_valid = 0;
        chk("R11 occupancy after squash", int'(occupancy), 1);
        push(4, 0, 0, id, sd);
        chk("R11 index reused", id, ib);
        commit(sd);
        idle(6);
        chk("R11 writes", wn, 2);
        chk("R11 second write is new store", wlog_addr[1], 16'h100 + sd);
        chk("R11 drained", int'(occupancy), 0);
    endtask

    task automatic t_full_wrap;
        int start, ix, sx;
        wn = 0;
        start = int'(alloc_idx);
        for (int k = 0; k < DEPTH - 1; k++) push(4, 0, 0, ix, sx);
        chk("R2 full occupancy", int'(occupancy), DEPTH - 1);
        chk("R2 full not ready", int'(alloc_ready), 0);
        alloc_valid = 1; alloc_seq = 8'(nseq);
        tick();
        alloc_valid = 0;
        chk("R2 alloc ignored when full", int'(occupancy), DEPTH - 1);
        commit(sx);
        idle(12);
        chk("R2 all written", wn, DEPTH - 1);
        for (int k = 0; k < DEPTH - 1; k++)
            chk("R2 wrapped order", wlog_idx[k], (start + k) % DEPTH);
        chk("R2 drained", int'(occupancy), 0);
    endtask

    task automatic t_stall;
        int ia, ib, sa, sb;
        wr_hit = 0;
        push(4, 0, 0, ia, sa); push(4, 0, 0, ib, sb);
        commit(sb);
        idle(4);
        wr_hit = 1;
        stall_set = 1; stall_seq = 8'(sb); stall_ld_idx = 4'd5;
        tick();
        stall_set = 0;
        cpl_valid = 1; cpl_idx = IW'(ia);
        tick();
        cpl_valid = 0;
        chk("R12 no replay on other store", int'(replay_valid), 0);
        cpl_valid = 1; cpl_idx = IW'(ib);
        tick();
        cpl_valid = 0;
        chk("R12 replay pulse", int'(replay_valid), 1);
        chk("R12 replay load idx", int'(replay_ld_idx), 5);
        tick();
        chk("R12 pulse one cycle", int'(replay_valid), 0);
        idle(2);
        chk("R12 drained", int'(occupancy), 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        tick();
        t_reset();
        t_commit_order();
        t_blocked_hold();
        t_miss_ooo();
        t_zero_pref_nonspec();
        t_squash();
        t_full_wrap();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule